// File: doc/BRIEF.md
# Interleaved Loop-Nest Iteration Issuer

This block produces the issue schedule for a two-level loop nest whose inner loop can only accept a new iteration every few cycles. The outer loop runs `OUTER_TRIPS` times and the inner loop runs `INNER_TRIPS` times. The inner loop has an initiation interval of `INIT_IVL` cycles. A plain nested counter would leave `INIT_IVL-1` empty cycles after every issue. This block instead fills those empty cycles with the same inner index taken from the next outer invocations. The number of outer invocations that share one window of `INIT_IVL` cycles is the effective degree `D`. `D` equals `INIT_IVL` when `MAX_DEG` is 0 or larger than `INIT_IVL`, and equals `MAX_DEG` otherwise.

Time is divided into windows of `INIT_IVL` slots. Slot `s` of a window carries outer index `base+s`, where `base` is the first outer index of the current group, for every `s < D`. The remaining slots stay empty. Slots whose outer index would reach `OUTER_TRIPS` also stay empty; they are not packed together. Once every inner index of a group has been issued, the group base moves up by `D`. A downstream consumer can stall an offered pair with `ready`. Empty slots do not wait for `ready`.

The block has three states. `ST_IDLE` waits for `start`. `ST_RUN` steps through the slots. `ST_FINISH` lasts one cycle and raises `done`. There are three transitions. *Launch* goes from `ST_IDLE` to `ST_RUN` when `start` is high. *Last accept* goes from `ST_RUN` to `ST_FINISH` when the final pair is taken. *Retire* goes from `ST_FINISH` to `ST_IDLE` unconditionally.

Top module: `lnest_issuer`

## Requirements
- R1: While reset is asserted and after it is released, `valid` and `done` are 0 until a sequence is launched.
- R2: A `start` sampled high in `ST_IDLE` makes the pair (outer 0, inner 0) appear with `valid` high in the next cycle.
- R3: With `D` = `INIT_IVL` when `MAX_DEG` is 0 or `MAX_DEG > INIT_IVL`, and `D` = `MAX_DEG` otherwise, slots with index `s >= D` inside each window of `INIT_IVL` slots carry `valid` 0.
- R4: Slot `s < D` of a window issues (`base+s`, `i`). Inner index `i` rises by one per window from 0 to `INNER_TRIPS-1`. `base` starts at 0 and grows by `D` after a group's last window.
- R5: In a group where `base+s >= OUTER_TRIPS`, that slot shows `valid` 0 and still takes one cycle.
- R6: While `valid` is 1 and `ready` is 0, the schedule does not advance, and `outer_idx` and `inner_idx` hold their values.
- R7: A slot with `valid` 0 advances to the next slot after one cycle, whatever the level of `ready`.
- R8: `done` is 1 for exactly one cycle, the cycle after the pair (`OUTER_TRIPS-1`, `INNER_TRIPS-1`) is accepted. `valid` is 0 in that cycle and stays 0 afterwards until the next launch.
- R9: `start` has no effect in `ST_RUN` or `ST_FINISH`: the schedule continues unchanged, and a `start` during the `done` cycle launches nothing.
- R10: When `D` is 1 (`MAX_DEG` = 1 or `INIT_IVL` = 1), every inner iteration of an outer index is issued before the next outer index appears. With `INIT_IVL` = 1 the issues are back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, only honoured in `ST_IDLE` |
| ready | input | 1 | Consumer accepts the offered pair this cycle |
| valid | output | 1 | An index pair is offered |
| outer_idx | output | max(1, clog2(OUTER_TRIPS)) | Outer loop index of the offered pair |
| inner_idx | output | max(1, clog2(INNER_TRIPS)) | Inner loop index of the offered pair |
| done | output | 1 | One-cycle pulse after the final pair is accepted |

## Verification
Two cases are tested where separate functions meet in one cycle. In the first, `start` arrives in the same cycle as the one-cycle `done` pulse, when *retire* is returning the machine to idle. The bench raises `start` exactly in that cycle and in the middle of a run, and then requires `valid` to remain 0 and the running schedule to match the arithmetic model unchanged. In the second, a stall meets an empty slot. Under a repeating `ready` pattern, a low `ready` sometimes falls on an offered pair, which must freeze, and sometimes on an empty slot, which must still move on. Each cycle is compared with a slot/inner/group model computed in the bench for five parameter sets. These include a partial final group and a `MAX_DEG` larger than the interval.

// File: rtl/lnest_pkg.sv
package lnest_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } lnest_state_e;

    // Effective number of outer invocations sharing one interval window.
    function automatic int eff_degree(input int ivl, input int max_deg);
        if (max_deg == 0 || max_deg > ivl) begin
            return ivl;
        end
        return max_deg;
    endfunction

endpackage

// File: rtl/lnest_step_ctr.sv
module lnest_step_ctr #(
    parameter int W    = 1,
    parameter int MAXV = 1,
    parameter int STEP = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         at_end
);

    int nxt;

    always_comb begin
        nxt    = int'(cnt) + STEP;
        at_end = (nxt > MAXV);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= at_end ? '0 : W'(nxt);
        end
    end

    // R4: the counter never leaves its legal range
    a_r4_ctr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= MAXV);

endmodule

// File: rtl/lnest_slot_gate.sv
module lnest_slot_gate #(
    parameter int OW     = 1,
    parameter int IW     = 1,
    parameter int SW     = 1,
    parameter int OUTERS = 1,
    parameter int INNERS = 1,
    parameter int DEG    = 1
) (
    input  logic [OW-1:0] grp_base,
    input  logic [IW-1:0] inner,
    input  logic [SW-1:0] slot,
    output logic          live,
    output logic          last,
    output logic [OW-1:0] outer
);

    int sum;

    always_comb begin
        sum   = int'(grp_base) + int'(slot);
        live  = (int'(slot) < DEG) && (sum < OUTERS);
        last  = live && (sum == OUTERS - 1) && (int'(inner) == INNERS - 1);
        outer = OW'(sum);
    end

endmodule

// File: rtl/lnest_issuer.sv
module lnest_issuer #(
    parameter int OUTER_TRIPS = 5,
    parameter int INNER_TRIPS = 5,
    parameter int INIT_IVL    = 2,
    parameter int MAX_DEG     = 0,
    localparam int OW = (OUTER_TRIPS < 2) ? 1 : $clog2(OUTER_TRIPS),
    localparam int IW = (INNER_TRIPS < 2) ? 1 : $clog2(INNER_TRIPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ready,
    output logic          valid,
    output logic [OW-1:0] outer_idx,
    output logic [IW-1:0] inner_idx,
    output logic          done
);

    import lnest_pkg::*;

    localparam int DEG = eff_degree(INIT_IVL, MAX_DEG);
    localparam int SW  = (INIT_IVL < 2) ? 1 : $clog2(INIT_IVL);

    lnest_state_e st, st_nxt;

    logic [SW-1:0] slot;
    logic [IW-1:0] inner;
    logic [OW-1:0] grp_base;
    logic          slot_end, inner_end, grp_end;
    logic          live, last, adv, clr;
    logic [OW-1:0] outer_w;

    // Step the schedule unless an offered pair is being held back.
    assign adv = (st == ST_RUN) && (!live || ready);
    assign clr = (st == ST_IDLE);

    lnest_step_ctr #(.W(SW), .MAXV(INIT_IVL - 1), .STEP(1)) slot_ctr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .inc    (adv && !last),
        .cnt    (slot),
        .at_end (slot_end)
    );

    lnest_step_ctr #(.W(IW), .MAXV(INNER_TRIPS - 1), .STEP(1)) inner_ctr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .inc    (adv && !last && slot_end),
        .cnt    (inner),
        .at_end (inner_end)
    );

    lnest_step_ctr #(.W(OW), .MAXV(OUTER_TRIPS - 1), .STEP(DEG)) grp_ctr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .inc    (adv && !last && slot_end && inner_end),
        .cnt    (grp_base),
        .at_end (grp_end)
    );

    lnest_slot_gate #(
        .OW(OW), .IW(IW), .SW(SW),
        .OUTERS(OUTER_TRIPS), .INNERS(INNER_TRIPS), .DEG(DEG)
    ) gate_i (
        .grp_base (grp_base),
        .inner    (inner),
        .slot     (slot),
        .live     (live),
        .last     (last),
        .outer    (outer_w)
    );

    // Next-state logic: launch, last accept, retire.
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:   if (start) st_nxt = ST_RUN;
            ST_RUN:    if (adv && last) st_nxt = ST_FINISH;
            ST_FINISH: st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        valid     = 1'b0;
        done      = 1'b0;
        outer_idx = outer_w;
        inner_idx = inner;
        unique case (st)
            ST_IDLE:   valid = 1'b0;
            ST_RUN:    valid = live;
            ST_FINISH: done  = 1'b1;
            default:   valid = 1'b0;
        endcase
    end

    // R6: a stalled pair stays on the outputs
    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(outer_idx) && $stable(inner_idx)));

    // R8: done follows acceptance of the final pair
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && int'(outer_idx) == OUTER_TRIPS - 1
               && int'(inner_idx) == INNER_TRIPS - 1) |=> done);

    // R8: done is a single-cycle pulse with nothing offered after it
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !valid));

    // R4: offered indices lie inside the trip counts
    a_r4_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (int'(outer_idx) < OUTER_TRIPS && int'(inner_idx) < INNER_TRIPS));

    // R4: the group base never wraps before the final pair
    a_r4_no_group_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !last && slot_end && inner_end) |-> !grp_end);

    // R9: start during a run does not disturb it
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && start && !(adv && last)) |=> (st == ST_RUN));

    // R3: no pair is offered from a slot at or beyond the degree
    a_r3_slot_limit: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (int'(slot) < DEG));

endmodule

// File: tb/lnest_issuer_tb_lane.sv
module lnest_issuer_tb_lane #(
    parameter int M  = 5,
    parameter int N  = 5,
    parameter int II = 2,
    parameter int MD = 0
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_fail,
    output logic fin
);

    localparam int D  = (MD == 0 || MD > II) ? II : MD;
    localparam int OW = (M < 2) ? 1 : $clog2(M);
    localparam int IW = (N < 2) ? 1 : $clog2(N);

    logic          start, ready, valid, done;
    logic [OW-1:0] oi;
    logic [IW-1:0] ii_o;

    lnest_issuer #(
        .OUTER_TRIPS(M), .INNER_TRIPS(N), .INIT_IVL(II), .MAX_DEG(MD)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ready     (ready),
        .valid     (valid),
        .outer_idx (oi),
        .inner_idx (ii_o),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cfg M=%0d N=%0d II=%0d MD=%0d t=%0t actual=%0d expected=%0d",
                     req, M, N, II, MD, $time, act, exp);
        end
    endtask

    // mode 0: ready always high, stray start mid-run; mode 1: ready pattern
    task automatic run_seq(input int mode);
        int    g, i, s;
        bit    fin_l, ev, rdy;
        string tag;
        @(negedge clk);
        start = 1'b1;
        ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        g = 0; i = 0; s = 0; fin_l = 1'b0;
        tag = "R2";
        for (int cyc = 0; cyc < 4000 && !fin_l; cyc++) begin
            ev = (s < D) && (g + s < M);
            if (cyc != 0 && tag != "R6" && tag != "R7") begin
                if (D == 1)        tag = "R10";
                else if (ev)       tag = "R4";
                else if (s >= D)   tag = "R3";
                else               tag = "R5";
            end
            chk(valid == ev, tag, int'(valid), int'(ev));
            if (ev) begin
                chk(int'(oi) == g + s, tag, int'(oi), g + s);
                chk(int'(ii_o) == i, tag, int'(ii_o), i);
            end
            chk(done == 1'b0, "R8", int'(done), 0);
            rdy   = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            ready = rdy;
            start = (mode == 0 && cyc == 3);   // R9 stray start
            if (ev && !rdy)       tag = "R6";
            else if (!ev && !rdy) tag = "R7";
            else                  tag = "R4";
            if (!ev || rdy) begin
                if (ev && g + s == M - 1 && i == N - 1) begin
                    fin_l = 1'b1;
                end else begin
                    s++;
                    if (s == II) begin
                        s = 0;
                        i++;
                        if (i == N) begin
                            i = 0;
                            g += D;
                        end
                    end
                end
            end
            @(negedge clk);
        end
        chk(fin_l, "R4", int'(fin_l), 1);
        chk(done == 1'b1, "R8", int'(done), 1);
        chk(valid == 1'b0, "R8", int'(valid), 0);
        start = 1'b1;                           // R9 start in the done cycle
        ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R8", int'(done), 0);
        chk(valid == 1'b0, "R9", int'(valid), 0);
        @(negedge clk);
        chk(valid == 1'b0, "R9", int'(valid), 0);
        chk(done == 1'b0, "R9", int'(done), 0);
    endtask

    initial begin
        n_chk  = 0;
        n_fail = 0;
        fin    = 1'b0;
        start  = 1'b0;
        ready  = 1'b0;
        @(negedge clk);
        chk(valid == 1'b0 && done == 1'b0, "R1", int'(valid), 0);
        wait (rst_n);
        @(negedge clk);
        chk(valid == 1'b0, "R1", int'(valid), 0);
        chk(done == 1'b0, "R1", int'(done), 0);
        run_seq(0);
        run_seq(1);
        fin = 1'b1;
    end

endmodule

// File: tb/lnest_issuer_tb_top.sv
`timescale 1ns/1ps
module lnest_issuer_tb_top;

    logic clk;
    logic rst_n;
    int   c0, c1, c2, c3, c4;
    int   f0, f1, f2, f3, f4;
    logic d0, d1, d2, d3, d4;

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    // Default-size nest with full interleave of two
    lnest_issuer_tb_lane #(.M(5), .N(5), .II(2), .MD(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .n_chk(c0), .n_fail(f0), .fin(d0));
    // Degree capped below the interval, partial last group (R3, R5)
    lnest_issuer_tb_lane #(.M(5), .N(3), .II(3), .MD(2)) lane1_i (
        .clk(clk), .rst_n(rst_n), .n_chk(c1), .n_fail(f1), .fin(d1));
    // Interleaving switched off (R10)
    lnest_issuer_tb_lane #(.M(3), .N(3), .II(2), .MD(1)) lane2_i (
        .clk(clk), .rst_n(rst_n), .n_chk(c2), .n_fail(f2), .fin(d2));
    // Unit interval, back-to-back issue (R10)
    lnest_issuer_tb_lane #(.M(3), .N(2), .II(1), .MD(0)) lane3_i (
        .clk(clk), .rst_n(rst_n), .n_chk(c3), .n_fail(f3), .fin(d3));
    // Setting above the interval clamps to the interval (R3)
    lnest_issuer_tb_lane #(.M(4), .N(2), .II(3), .MD(5)) lane4_i (
        .clk(clk), .rst_n(rst_n), .n_chk(c4), .n_fail(f4), .fin(d4));

    initial begin
        int total, failed;
        bit all_fin;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        all_fin = 1'b0;
        for (int c = 0; c < 200000 && !all_fin; c++) begin
            @(posedge clk);
            all_fin = d0 && d1 && d2 && d3 && d4;
        end
        total  = c0 + c1 + c2 + c3 + c4;
        failed = f0 + f1 + f2 + f3 + f4;
        if (!all_fin) begin
            total++;
            failed++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule